// File: doc/BRIEF.md
# Recursive Averaging Filter Datapath

This block keeps a running average of a video sample stream. Every sample has a matching 12-bit stored word, held in an external memory. On each sample the block takes the difference between the 8-bit input and the upper 8 bits of the stored word. It adds that difference, sign-extended, into the full 12-bit word. Each pass therefore moves the stored value one sixteenth of the way toward the input. The updated word is registered and presented for write-back together with a one-cycle write strobe.

A bypass control replaces the filtered result with the raw sample, placed in the upper byte with the low nibble cleared. This loads storage directly. While an external agent holds the memory bus, the block neither drives the write bus nor raises its strobe. An 8-bit converter output captures the upper byte of whatever word is on the memory bus. It does so on the same enable edge that registers the new filter result.

All timing is taken from a single clock qualified by a sample enable, which stands for the sample-clock edge.

Top module: `recursive_avg_dp`

## Requirements
- R1: After reset, the write strobe is low, the write bus value is 0x000 and the converter output is 0x00.
- R2: The sample input is captured only on a cycle with the sample enable high. With the enable low, changes on the input have no effect on the next filter result.
- R3: On a sample-enable cycle the block registers new = old + sext(in_q − old[11:4]) modulo 4096. Here old is the stored-word read port in that cycle and in_q is the sample captured on the previous enable.
- R4: A negative difference decrements the upper nibble through the borrow path. For example, old 0x100 with input 0x00 gives 0x0F0, and old 0xFF8 with input 0x00 gives 0xEF9.
- R5: With bypass high the write bus carries {in_q, 4'b0000}, captured on the enable edge. With bypass low it carries the filtered word from the same edge.
- R6: While the memory-access input is high, the write strobe and the write-bus drive enable are both low.
- R7: The write strobe is high for exactly the one cycle that follows each sample-enable cycle, unless memory access is active.
- R8: On a sample-enable edge the converter output captures bits [11:4] of the memory bus. The memory bus is the block's write word while access is idle, and the read port while access is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_en | input | 1 | Sample-clock edge qualifier |
| samp_in | input | 8 | Incoming video sample |
| store_rd | input | 12 | Stored word read back for the current sample |
| bypass | input | 1 | 1: write the raw sample, 0: write the filtered word |
| mem_access | input | 1 | External agent owns the memory bus |
| store_wr_data | output | 12 | Word to write back to storage |
| store_wr_oe | output | 1 | Drive enable for the write bus |
| store_wr_en | output | 1 | Write strobe |
| dac_out | output | 8 | Sample for the output converter |

## Verification
Two functions share one edge: the converter capture and the filter-result register both load on the same sample-enable cycle. The bench checks that the converter gets the bus word from before that edge, not the word just computed. A second case raises memory access in the same cycle as an enable edge. In that case the converter must take the read port's upper byte, and in the following cycle the strobe must stay low while the new filter result is still held.

// File: rtl/avg_pkg.sv
package avg_pkg;
  typedef enum logic {SRC_FILT = 1'b0, SRC_RAW = 1'b1} src_sel_e;
endpackage

// File: rtl/avg_sample_reg.sv
module avg_sample_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(q));
endmodule

// File: rtl/avg_update.sv
module avg_update #(
  parameter int SAMPLE_W = 8,
  parameter int FRAC_W   = 4,
  localparam int WORD_W  = SAMPLE_W + FRAC_W
) (
  input  logic [SAMPLE_W-1:0] in_s,
  input  logic [WORD_W-1:0]   old_w,
  output logic [WORD_W-1:0]   new_w
);
  logic [SAMPLE_W:0]   diff;
  logic [SAMPLE_W-1:0] err;
  logic                neg;
  logic [SAMPLE_W:0]   lo_sum;
  logic [FRAC_W-1:0]   hi_sum;

  always_comb begin
    // subtract by adding the inverted upper byte plus one
    diff   = {1'b0, in_s} + {1'b0, ~old_w[WORD_W-1:FRAC_W]} + {{SAMPLE_W{1'b0}}, 1'b1};
    err    = diff[SAMPLE_W-1:0];
    neg    = ~diff[SAMPLE_W];
    lo_sum = {1'b0, old_w[SAMPLE_W-1:0]} + {1'b0, err};
    // carry increments, a borrow adds all ones (decrement)
    hi_sum = old_w[WORD_W-1:SAMPLE_W]
           + {{(FRAC_W-1){1'b0}}, lo_sum[SAMPLE_W]}
           + {FRAC_W{neg}};
    new_w  = {hi_sum, lo_sum[SAMPLE_W-1:0]};
  end

  always_comb begin
    if (in_s == old_w[WORD_W-1:FRAC_W])
      assert_zero_err_R3: assert (new_w == old_w);
  end
endmodule

// File: rtl/avg_out_stage.sv
module avg_out_stage
  import avg_pkg::*;
#(
  parameter int SAMPLE_W = 8,
  parameter int FRAC_W   = 4,
  localparam int WORD_W  = SAMPLE_W + FRAC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_en,
  input  logic [WORD_W-1:0]   filt_sum,
  input  logic [SAMPLE_W-1:0] raw_in,
  input  logic                bypass,
  input  logic                mem_access,
  input  logic [WORD_W-1:0]   bus_in,
  output logic [WORD_W-1:0]   wr_data,
  output logic                wr_oe,
  output logic                wr_en,
  output logic [SAMPLE_W-1:0] dac
);
  logic [WORD_W-1:0]   filt_q, filt_nxt;
  logic [SAMPLE_W-1:0] raw_q, raw_nxt;
  logic [SAMPLE_W-1:0] dac_q, dac_nxt;
  logic                pend_q, pend_nxt;
  src_sel_e            sel;
  logic [WORD_W-1:0]   own_word;
  logic [WORD_W-1:0]   bus_word;

  always_comb begin
    sel      = bypass ? SRC_RAW : SRC_FILT;
    own_word = (sel == SRC_RAW) ? {raw_q, {FRAC_W{1'b0}}} : filt_q;
    bus_word = mem_access ? bus_in : own_word;
    filt_nxt = samp_en ? filt_sum : filt_q;
    raw_nxt  = samp_en ? raw_in : raw_q;
    dac_nxt  = samp_en ? bus_word[WORD_W-1:FRAC_W] : dac_q;
    pend_nxt = samp_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_q <= '0;
      raw_q  <= '0;
      dac_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      filt_q <= filt_nxt;
      raw_q  <= raw_nxt;
      dac_q  <= dac_nxt;
      pend_q <= pend_nxt;
    end
  end

  assign wr_data = own_word;
  assign wr_oe   = ~mem_access;
  assign wr_en   = pend_q & ~mem_access;
  assign dac     = dac_q;

  assert_strobe_after_en_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(samp_en));
  assert_bypass_low_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bypass) |-> (wr_data[FRAC_W-1:0] == '0));
  assert_dac_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !samp_en |=> $stable(dac));
endmodule

// File: rtl/recursive_avg_dp.sv
module recursive_avg_dp #(
  parameter int SAMPLE_W = 8,
  parameter int FRAC_W   = 4,
  localparam int WORD_W  = SAMPLE_W + FRAC_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                samp_en,
  input  logic [SAMPLE_W-1:0] samp_in,
  input  logic [WORD_W-1:0]   store_rd,
  input  logic                bypass,
  input  logic                mem_access,
  output logic [WORD_W-1:0]   store_wr_data,
  output logic                store_wr_oe,
  output logic                store_wr_en,
  output logic [SAMPLE_W-1:0] dac_out
);
  logic [SAMPLE_W-1:0] in_q;
  logic [WORD_W-1:0]   sum;

  avg_sample_reg #(.W(SAMPLE_W)) u_in (
    .clk(clk), .rst_n(rst_n), .en(samp_en), .d(samp_in), .q(in_q)
  );

  avg_update #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_upd (
    .in_s(in_q), .old_w(store_rd), .new_w(sum)
  );

  avg_out_stage #(.SAMPLE_W(SAMPLE_W), .FRAC_W(FRAC_W)) u_out (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .filt_sum(sum),
    .raw_in(in_q), .bypass(bypass), .mem_access(mem_access),
    .bus_in(store_rd), .wr_data(store_wr_data), .wr_oe(store_wr_oe),
    .wr_en(store_wr_en), .dac(dac_out)
  );

  assert_no_write_on_access_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_access |-> (!store_wr_en && !store_wr_oe));
  assert_strobe_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (store_wr_en && !samp_en) |=> !store_wr_en);
endmodule

// File: tb/test_recursive_avg_dp.sv
module test_recursive_avg_dp;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        samp_en;
  logic [7:0]  samp_in;
  logic [11:0] store_rd;
  logic        bypass;
  logic        mem_access;
  logic [11:0] store_wr_data;
  logic        store_wr_oe;
  logic        store_wr_en;
  logic [7:0]  dac_out;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  recursive_avg_dp i_recursive_avg_dp (
    .clk(clk), .rst_n(rst_n), .samp_en(samp_en), .samp_in(samp_in),
    .store_rd(store_rd), .bypass(bypass), .mem_access(mem_access),
    .store_wr_data(store_wr_data), .store_wr_oe(store_wr_oe),
    .store_wr_en(store_wr_en), .dac_out(dac_out)
  );

  function automatic logic [11:0] model(input logic [11:0] old, input logic [7:0] x);
    logic [11:0] e;
    e = {4'h0, x} - {4'h0, old[11:4]};
    return old + e;
  endfunction

  task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] d, input logic [11:0] rd);
    @(negedge clk);
    samp_en = 1'b1; samp_in = d; store_rd = rd;
    @(negedge clk);
    samp_en = 1'b0;
    #1;
  endtask

  task automatic t_reset;
    check("R1 strobe", {11'b0, store_wr_en}, 12'h0);
    check("R1 wr_data", store_wr_data, 12'h000);
    check("R1 dac", {4'h0, dac_out}, 12'h000);
  endtask

  task automatic t_hold;
    pulse(8'h5A, 12'h000);
    repeat (3) begin @(negedge clk); samp_in = 8'hFF; end
    pulse(8'h00, 12'h000);
    check("R2 held sample", store_wr_data, 12'h05A);
  endtask

  task automatic t_update;
    logic [7:0]  xs [4] = '{8'h80, 8'hFF, 8'h10, 8'hC3};
    logic [11:0] os [4] = '{12'h123, 12'h000, 12'h105, 12'hC30};
    for (int i = 0; i < 4; i++) begin
      pulse(xs[i], 12'h000);
      pulse(8'h00, os[i]);
      check("R3 update", store_wr_data, model(os[i], xs[i]));
    end
  endtask

  task automatic t_neg;
    pulse(8'h00, 12'h000);
    pulse(8'h00, 12'h100);
    check("R4 borrow", store_wr_data, 12'h0F0);
    pulse(8'h00, 12'hFF8);
    check("R4 borrow wide", store_wr_data, 12'hEF9);
  endtask

  task automatic t_strobe;
    pulse(8'h11, 12'h000);
    check("R7 strobe high", {11'b0, store_wr_en}, 12'h1);
    @(negedge clk); #1;
    check("R7 strobe one cycle", {11'b0, store_wr_en}, 12'h0);
  endtask

  task automatic t_bypass;
    bypass = 1'b1;
    pulse(8'hA7, 12'h000);
    pulse(8'h00, 12'h555);
    check("R5 raw word", store_wr_data, 12'hA70);
    bypass = 1'b0; #1;
    check("R5 filtered word", store_wr_data, 12'h5A7);
  endtask

  task automatic t_access;
    pulse(8'h40, 12'h000);
    @(negedge clk);
    samp_en = 1'b1; store_rd = 12'h000;
    @(negedge clk);
    samp_en = 1'b0; mem_access = 1'b1; #1;
    check("R6 strobe blocked", {11'b0, store_wr_en}, 12'h0);
    check("R6 drive off", {11'b0, store_wr_oe}, 12'h0);
    @(negedge clk); mem_access = 1'b0; #1;
    check("R6 result kept", store_wr_data, 12'h040);
  endtask

  task automatic t_dac;
    pulse(8'h20, 12'h000);
    pulse(8'h30, 12'h100);
    pulse(8'h00, 12'h000);
    check("R8 dac prior word", {4'h0, dac_out}, 12'h011);
    @(negedge clk);
    samp_en = 1'b1; mem_access = 1'b1; store_rd = 12'hAB0;
    @(negedge clk);
    samp_en = 1'b0; mem_access = 1'b0; #1;
    check("R8 dac from read port", {4'h0, dac_out}, 12'h0AB);
  endtask

  initial begin
    rst_n = 1'b0; samp_en = 1'b0; samp_in = '0; store_rd = '0;
    bypass = 1'b0; mem_access = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    t_reset();
    t_hold();
    t_update();
    t_neg();
    t_strobe();
    t_bypass();
    t_access();
    t_dac();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule